// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Unit

This block is a purely combinational shifter. It sits in front of the second ALU input of a 32-bit datapath. It takes a source word, a 2-bit shift kind, a 5-bit immediate shift amount, a select for the single-step rotate through carry, and the current carry flag. It returns the shifted operand and the carry the shifter produces, which is the last bit pushed out of the word.

An invert control returns the one's complement of the shifted word, so a move-not operation can use the same path. The carry output is not affected by the invert control.

When the amount is zero and the carry-rotate select is low, the word passes through unchanged and the incoming carry is returned. When the carry-rotate select is high, the carry flag acts as a 33rd bit that sits below bit 0. The word then moves right by exactly one place, whatever the amount and kind inputs hold.

Top module: `opnd_shifter`

## Requirements
- R1: With shift_kind = 2'b00 (logical left) and amount n in 1..31, bit i of the result is src_val[i-n] for i >= n and 0 below that, and carry_out is src_val[32-n].
- R2: With shift_kind = 2'b01 (logical right) and amount n in 1..31, bit i of the result is src_val[i+n] for i+n <= 31 and 0 above that, and carry_out is src_val[n-1].
- R3: With shift_kind = 2'b10 (arithmetic right) and amount n in 1..31, the vacated upper bits are copies of src_val[31], the other bits follow R2, and carry_out is src_val[n-1].
- R4: With shift_kind = 2'b11 (rotate right) and amount n in 1..31, bit i of the result is src_val[(i+n) mod 32], and carry_out is src_val[n-1].
- R5: With rrx_sel = 1, the result is {carry_in, src_val[31:1]} and carry_out is src_val[0], for every value of shift_kind and shift_amt.
- R6: With rrx_sel = 0 and shift_amt = 0, the result equals src_val and carry_out equals carry_in, for every shift_kind.
- R7: With invert = 1, opnd_out is the bitwise complement of the result that invert = 0 gives, and carry_out is the same as with invert = 0.
- R8: With all inputs at zero, opnd_out is 0 and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 32 | Word to be shifted |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| shift_amt | input | 5 | Immediate shift amount, 0 to 31 |
| rrx_sel | input | 1 | One-place rotate right through carry; overrides kind and amount |
| carry_in | input | 1 | Current carry flag |
| invert | input | 1 | Return the one's complement of the shifted word |
| opnd_out | output | 32 | Shifted, optionally inverted, operand |
| carry_out | output | 1 | Last bit shifted out, or carry_in on a zero shift |

## Verification
Each shift kind is swept over every amount from 1 to 31 on several source words. A word with an irregular bit pattern shows whether bits land in the wrong place. The all-ones and all-zeros words show whether the fill bits are correct. A word with bit 31 set separates arithmetic from logical right shift, and a word with bits set at both ends shows whether rotation wraps. The single-step carry rotate is run with both carry values and with unrelated amount and kind inputs, which shows that those inputs are overridden. Zero-amount cases and inverted cases are repeated with both carry values, so that a carry-out that ignores carry_in, or one that changes with invert, is caught.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  // Bit that enters from the top on a right shift of a non-rotating kind.
  function automatic logic right_fill(input shift_kind_e kind, input logic msb);
    return (kind == SK_ASR) ? msb : 1'b0;
  endfunction

  function automatic logic is_left(input shift_kind_e kind);
    return kind == SK_LSL;
  endfunction

  function automatic logic is_rotate(input shift_kind_e kind);
    return kind == SK_ROR;
  endfunction

endpackage

// File: rtl/opsh_barrel.sv
module opsh_barrel #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]   val,
  input  opsh_pkg::shift_kind_e kind,
  input  logic [AMT_W-1:0]    amt,
  output logic [DATA_W-1:0]   res
);
  import opsh_pkg::*;

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = x[DATA_W-1-i];
    return r;
  endfunction

  logic                           go_left;
  logic                           rotate;
  logic                           fill_bit;
  logic [AMT_W:0][DATA_W-1:0]     stg;

  assign go_left  = is_left(kind);
  assign rotate   = is_rotate(kind);
  // Left shifts run through the right-shift network on a mirrored word.
  assign fill_bit = go_left ? 1'b0 : right_fill(kind, val[DATA_W-1]);
  assign stg[0]   = go_left ? bit_rev(val) : val;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [DATA_W-1:0] moved;
    always_comb begin
      if (rotate)
        moved = {stg[s][K-1:0], stg[s][DATA_W-1:K]};
      else
        moved = (stg[s] >> K) | (fill_bit ? ~({DATA_W{1'b1}} >> K) : '0);
    end
    assign stg[s+1] = amt[s] ? moved : stg[s];
  end

  assign res = go_left ? bit_rev(stg[AMT_W]) : stg[AMT_W];

endmodule

// File: rtl/opsh_carry.sv
module opsh_carry #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]     val,
  input  opsh_pkg::shift_kind_e kind,
  input  logic [AMT_W-1:0]      amt,
  output logic                  cout
);
  import opsh_pkg::*;

  logic [AMT_W-1:0] pick;

  // Left: last bit out sits at DATA_W-amt (modulo wrap gives that directly).
  // Right kinds: last bit out sits at amt-1. Only valid for amt != 0.
  always_comb begin
    if (is_left(kind))
      pick = AMT_W'(DATA_W) - amt;
    else
      pick = amt - 1'b1;
  end

  assign cout = val[pick];

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_val,
  input  logic [1:0]        shift_kind,
  input  logic [AMT_W-1:0]  shift_amt,
  input  logic              rrx_sel,
  input  logic              carry_in,
  input  logic              invert,
  output logic [DATA_W-1:0] opnd_out,
  output logic              carry_out
);
  import opsh_pkg::*;

  shift_kind_e       kind;
  logic [DATA_W-1:0] barrel_res;
  logic              barrel_cout;
  logic              amt_zero;
  logic [DATA_W-1:0] shifted_val;
  logic              shift_cout;

  assign kind     = shift_kind_e'(shift_kind);
  assign amt_zero = (shift_amt == '0);

  opsh_barrel #(.DATA_W(DATA_W)) i_barrel (
    .val  (src_val),
    .kind (kind),
    .amt  (shift_amt),
    .res  (barrel_res)
  );

  opsh_carry #(.DATA_W(DATA_W)) i_carry (
    .val  (src_val),
    .kind (kind),
    .amt  (shift_amt),
    .cout (barrel_cout)
  );

  always_comb begin
    if (rrx_sel) begin
      shifted_val = {carry_in, src_val[DATA_W-1:1]};
      shift_cout  = src_val[0];
    end else if (amt_zero) begin
      shifted_val = src_val;
      shift_cout  = carry_in;
    end else begin
      shifted_val = barrel_res;
      shift_cout  = barrel_cout;
    end
  end

  assign opnd_out  = invert ? ~shifted_val : shifted_val;
  assign carry_out = shift_cout;

endmodule

// File: rtl/opsh_checker.sv
module opsh_checker #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] src_val,
  input logic [1:0]        shift_kind,
  input logic [AMT_W-1:0]  shift_amt,
  input logic              rrx_sel,
  input logic              carry_in,
  input logic              invert,
  input logic [DATA_W-1:0] opnd_out,
  input logic              carry_out,
  input logic [DATA_W-1:0] shifted_val
);
  logic active_shift;
  assign active_shift = !rrx_sel && (shift_amt != '0);

  always_comb begin
    if (active_shift && shift_kind == 2'b00)
      AST_LSL_LOW_ZERO: assert (shifted_val[0] == 1'b0); // R1
    if (active_shift && shift_kind == 2'b01)
      AST_LSR_TOP_ZERO: assert (shifted_val[DATA_W-1] == 1'b0); // R2
    if (active_shift && shift_kind == 2'b10)
      AST_ASR_SIGN_KEPT: assert (shifted_val[DATA_W-1] == src_val[DATA_W-1]); // R3
    if (active_shift && shift_kind == 2'b11)
      AST_ROR_ONES_KEPT: assert ($countones(shifted_val) == $countones(src_val)); // R4
    if (active_shift && shift_kind == 2'b11)
      AST_ROR_CARRY_MSB: assert (carry_out == shifted_val[DATA_W-1]); // R4
    if (rrx_sel)
      AST_RRX_STEP: assert (carry_out == src_val[0] && shifted_val == {carry_in, src_val[DATA_W-1:1]}); // R5
    if (!rrx_sel && shift_amt == '0)
      AST_ZERO_PASS: assert (carry_out == carry_in && shifted_val == src_val); // R6
    AST_INV_MATCH: assert ((opnd_out ^ shifted_val) == {DATA_W{invert}}); // R7
  end

endmodule

bind opnd_shifter opsh_checker #(.DATA_W(DATA_W)) i_opsh_checker (
  .src_val     (src_val),
  .shift_kind  (shift_kind),
  .shift_amt   (shift_amt),
  .rrx_sel     (rrx_sel),
  .carry_in    (carry_in),
  .invert      (invert),
  .opnd_out    (opnd_out),
  .carry_out   (carry_out),
  .shifted_val (shifted_val)
);

// File: tb/test_opnd_shifter.sv
module test_opnd_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int WATCHDOG_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  src_val = '0;
  logic [1:0]    shift_kind = '0;
  logic [4:0]    shift_amt = '0;
  logic          rrx_sel = 1'b0;
  logic          carry_in = 1'b0;
  logic          invert = 1'b0;
  logic [W-1:0]  opnd_out;
  logic          carry_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_shifter i_opnd_shifter (
    .src_val    (src_val),
    .shift_kind (shift_kind),
    .shift_amt  (shift_amt),
    .rrx_sel    (rrx_sel),
    .carry_in   (carry_in),
    .invert     (invert),
    .opnd_out   (opnd_out),
    .carry_out  (carry_out)
  );

  logic [W-1:0] patterns [5] = '{32'h4F5D6E3A, 32'h80000001, 32'hFFFFFFFF,
                                  32'h00000000, 32'hA5C30F96};

  // Reference: bit-by-bit placement from the requirement formulas.
  task automatic model(input logic [W-1:0] v, input logic [1:0] k, input int n,
                       input logic rrx, input logic cin,
                       output logic [W-1:0] r, output logic c);
    if (rrx) begin
      for (int i = 0; i < W-1; i++) r[i] = v[i+1];
      r[W-1] = cin;
      c = v[0];
    end else if (n == 0) begin
      r = v; c = cin;
    end else begin
      for (int i = 0; i < W; i++) begin
        case (k)
          2'b00: r[i] = (i >= n) ? v[i-n] : 1'b0;
          2'b01: r[i] = (i + n <= W-1) ? v[i+n] : 1'b0;
          2'b10: r[i] = (i + n <= W-1) ? v[i+n] : v[W-1];
          default: r[i] = v[(i+n) % W];
        endcase
      end
      c = (k == 2'b00) ? v[W-n] : v[n-1];
    end
  endtask

  task automatic apply(input logic [W-1:0] v, input logic [1:0] k, input int n,
                       input logic rrx, input logic cin, input logic inv);
    @(negedge clk);
    src_val = v; shift_kind = k; shift_amt = 5'(n);
    rrx_sel = rrx; carry_in = cin; invert = inv;
    #(CLK_PERIOD/4);
  endtask

  task automatic compare(input string req, input logic [W-1:0] exp_r, input logic exp_c);
    checks++;
    if (opnd_out !== exp_r || carry_out !== exp_c) begin
      failures++;
      $display("FAIL %s: src=%h kind=%b amt=%0d rrx=%b cin=%b inv=%b got out=%h c=%b exp out=%h c=%b",
               req, src_val, shift_kind, shift_amt, rrx_sel, carry_in, invert,
               opnd_out, carry_out, exp_r, exp_c);
    end
  endtask

  task automatic run_case(input string req, input logic [W-1:0] v, input logic [1:0] k,
                          input int n, input logic rrx, input logic cin, input logic inv);
    logic [W-1:0] r; logic c;
    model(v, k, n, rrx, cin, r, c);
    apply(v, k, n, rrx, cin, inv);
    compare(req, inv ? ~r : r, c);
  endtask

  task automatic t_reset_state();  // R8
    apply('0, 2'b00, 0, 1'b0, 1'b0, 1'b0);
    compare("R8", '0, 1'b0);
  endtask

  task automatic t_kind_sweep(input string req, input logic [1:0] k);
    foreach (patterns[p])
      for (int n = 1; n < W; n++)
        for (int ci = 0; ci < 2; ci++)
          run_case(req, patterns[p], k, n, 1'b0, ci[0], 1'b0);
  endtask

  task automatic t_lsl_fixed();  // R1: 3 << 4 = 0x30, and top-bit carry on 1-place shift
    apply(32'h00000003, 2'b00, 4, 1'b0, 1'b1, 1'b0);
    compare("R1", 32'h00000030, 1'b0);
    apply(32'h80000000, 2'b00, 1, 1'b0, 1'b0, 1'b0);
    compare("R1", 32'h00000000, 1'b1);
  endtask

  task automatic t_asr_fixed();  // R3
    apply(32'h80000000, 2'b10, 31, 1'b0, 1'b0, 1'b0);
    compare("R3", 32'hFFFFFFFF, 1'b0);
    apply(32'h80000000, 2'b01, 31, 1'b0, 1'b0, 1'b0);
    compare("R2", 32'h00000001, 1'b0);
  endtask

  task automatic t_rrx();  // R5: amount and kind ignored
    foreach (patterns[p])
      for (int k = 0; k < 4; k++)
        for (int ci = 0; ci < 2; ci++)
          run_case("R5", patterns[p], 2'(k), (p * 7 + k * 5) % W, 1'b1, ci[0], 1'b0);
    apply(32'h00000001, 2'b11, 9, 1'b1, 1'b1, 1'b0);
    compare("R5", 32'h80000000, 1'b1);
  endtask

  task automatic t_zero_amt();  // R6
    foreach (patterns[p])
      for (int k = 0; k < 4; k++)
        for (int ci = 0; ci < 2; ci++)
          run_case("R6", patterns[p], 2'(k), 0, 1'b0, ci[0], 1'b0);
  endtask

  task automatic t_invert();  // R7
    foreach (patterns[p])
      for (int k = 0; k < 4; k++)
        for (int n = 0; n < W; n += 5)
          run_case("R7", patterns[p], 2'(k), n, 1'b0, n[0], 1'b1);
    run_case("R7", 32'h00000002, 2'b00, 0, 1'b1, 1'b1, 1'b1);
    apply(32'h00000002, 2'b00, 0, 1'b0, 1'b0, 1'b1);
    compare("R7", 32'hFFFFFFFD, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_lsl_fixed();
    t_kind_sweep("R1", 2'b00);
    t_kind_sweep("R2", 2'b01);
    t_asr_fixed();
    t_kind_sweep("R3", 2'b10);
    t_kind_sweep("R4", 2'b11);
    t_rrx();
    t_zero_amt();
    t_invert();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles >= WATCHDOG_CYCLES) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule